// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

The matcher pairs the N inputs of a crossbar with its N outputs so that no input and no output appears in more than one pair. A start pulse captures an N×N request matrix. The block then runs request/grant rounds, one per clock cycle. In each round, every still-free input names a single free output that it holds a cell for. The input picks it by scanning round-robin from its own request pointer. Every free output that was named accepts one of the inputs that named it, scanning round-robin from its own grant pointer. Each accepted pair is locked in for the rest of the slot.

The rounds stop when a round adds no pair, or when the configured round limit is reached. A one-cycle done strobe then marks the per-input valid bits and matched output indices as final. These results stay unchanged until the next start pulse. Only the outcome of the first round moves the pointers, each by one position. This spreads the pointers apart over successive slots, so that with full request matrices they stop colliding.

Top module: `rr_xbar_matcher`

## Requirements
- R1: After reset, `done` is low, every `match_vld` bit is low, and every request and grant pointer is zero.
- R2: A result never gives one output to two inputs. Every valid pair (i, j) has request bit `req_mat[i*N + j]` set in the captured matrix. Input i's output index sits in `match_out[i*LW +: LW]`, with LW = log2(N), and reads zero when input i is unmatched.
- R3: In every round, each unmatched input requests exactly one output. That output is the first one, scanning upward with wrap-around from the input's pointer, that is unmatched and has its request bit set.
- R4: Each unmatched output that receives requests grants the first requesting input, scanning upward with wrap-around from the output's grant pointer. The granted input and output are then both matched.
- R5: After the first round, a granted input's pointer becomes (pointer+1) mod N, and so does the pointer of each output that granted. Grants in later rounds leave all pointers unchanged.
- R6: Rounds repeat until a round produces no grant or MAX_ITER rounds have run. `done` rises in the cycle after the last round, so the start-to-done latency in cycles equals the number of rounds run.
- R7: `done` is high for exactly one cycle. After it, `match_vld` and `match_out` hold their values until the next accepted start.
- R8: An input whose request row is empty, or whose requested outputs are all taken, stays unmatched, and its pointer does not move.
- R9: A start pulse that arrives while rounds are still running is ignored, along with any change of `req_mat` in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new time slot and captures `req_mat` |
| req_mat | input | N*N | Request matrix, bit i*N+j = input i has a cell for output j |
| done | output | 1 | One-cycle strobe, results final |
| match_vld | output | N | Bit i set when input i is matched |
| match_out | output | N*LW | Matched output index per input, LW bits each |

## Verification
The bench keeps its own copy of every pointer. It predicts each slot round by round, so a pointer that moves in a later round, or fails to move, shows up as a wrong pair in a following slot. Full matrices that are repeated slot after slot drive the pointer desynchronisation. A single-column matrix makes one output arbitrate the same inputs over and over, and a grant pointer that did not rotate would keep favouring one input. Empty rows and empty matrices check that an idle input stays unmatched and that the block stops after a single empty round. Start pulses with a different matrix during busy rounds would corrupt the result, or the round count, of a design that accepted them.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int MAXW = 64;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} xbar_state_e;

  // first set position at or after ptr, wrapping modulo n; -1 when none
  function automatic int rr_first(input logic [MAXW-1:0] v, input int ptr, input int n);
    int pos;
    rr_first = -1;
    for (int k = MAXW - 1; k >= 0; k--) begin
      if (k < n) begin
        pos = (ptr + k) % n;
        if (v[pos]) rr_first = pos;
      end
    end
  endfunction

  function automatic int ptr_step(input int ptr, input int n);
    return (ptr + 1) % n;
  endfunction

endpackage

// File: rtl/xbar_rr_sel.sv
module xbar_rr_sel #(
  parameter int N = 16,
  localparam int LW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] cand,
  input  logic         adv,
  output logic [N-1:0] pick_oh
);
  logic [LW-1:0] ptr_q;
  int            pick;

  always_comb begin
    pick_oh = '0;
    pick = xbar_pkg::rr_first(xbar_pkg::MAXW'(cand), int'(ptr_q), N);
    if (en && pick >= 0) pick_oh[pick[LW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= LW'(xbar_pkg::ptr_step(int'(ptr_q), N));
  end
endmodule

// File: rtl/xbar_match_reg.sv
module xbar_match_reg #(
  parameter int N = 16,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [N-1:0]  set,
  input  logic [N*LW-1:0] idx_in,
  output logic [N-1:0]  vld,
  output logic [N*LW-1:0] idx_out
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[i]              <= 1'b0;
        idx_out[i*LW +: LW] <= '0;
      end else if (clear) begin
        vld[i]              <= 1'b0;
        idx_out[i*LW +: LW] <= '0;
      end else if (set[i]) begin
        vld[i]              <= 1'b1;
        idx_out[i*LW +: LW] <= idx_in[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/rr_xbar_matcher.sv
module rr_xbar_matcher #(
  parameter int N = 16,
  parameter int MAX_ITER = 4,
  localparam int LW = $clog2(N),
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N*N-1:0]  req_mat,
  output logic            done,
  output logic [N-1:0]    match_vld,
  output logic [N*LW-1:0] match_out
);
  import xbar_pkg::*;

  xbar_state_e     state_q;
  logic [N*N-1:0]  req_q;
  logic [IW-1:0]   iter_q;
  logic [N-1:0]    out_m;
  logic            done_q;

  logic            busy, start_acc, first_iter, last_iter, any_gnt;
  logic [N-1:0]    req_oh  [N];
  logic [N-1:0]    req_col [N];
  logic [N-1:0]    gnt_oh  [N];
  logic [N-1:0]    in_gnt;
  logic [N-1:0]    out_gnt;
  logic [N*LW-1:0] gnt_idx;

  assign busy       = (state_q == ST_BUSY);
  assign start_acc  = start && !busy;
  assign first_iter = busy && (iter_q == '0);
  assign any_gnt    = |in_gnt;
  assign last_iter  = busy && (!any_gnt || iter_q == IW'(MAX_ITER - 1));

  // request stage: one picker per input
  for (genvar i = 0; i < N; i++) begin : g_in
    xbar_rr_sel #(.N(N)) u_req (
      .clk(clk), .rst_n(rst_n),
      .en(busy && !match_vld[i]),
      .cand(req_q[i*N +: N] & ~out_m),
      .adv(first_iter && in_gnt[i]),
      .pick_oh(req_oh[i])
    );
  end

  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        req_col[o][i] = req_oh[i][o];
  end

  // grant stage: one picker per output
  for (genvar o = 0; o < N; o++) begin : g_out
    xbar_rr_sel #(.N(N)) u_gnt (
      .clk(clk), .rst_n(rst_n),
      .en(busy && !out_m[o]),
      .cand(req_col[o]),
      .adv(first_iter && out_gnt[o]),
      .pick_oh(gnt_oh[o])
    );
    assign out_gnt[o] = |gnt_oh[o];
  end

  always_comb begin
    in_gnt  = '0;
    gnt_idx = '0;
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        if (gnt_oh[o][i]) begin
          in_gnt[i]            = 1'b1;
          gnt_idx[i*LW +: LW]  = LW'(o);
        end
  end

  xbar_match_reg #(.N(N)) u_match (
    .clk(clk), .rst_n(rst_n),
    .clear(start_acc),
    .set(in_gnt),
    .idx_in(gnt_idx),
    .vld(match_vld),
    .idx_out(match_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      iter_q  <= '0;
      out_m   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_iter;
      if (start_acc) begin
        state_q <= ST_BUSY;
        req_q   <= req_mat;
        iter_q  <= '0;
        out_m   <= '0;
      end else if (busy) begin
        out_m  <= out_m | out_gnt;
        iter_q <= iter_q + IW'(1);
        if (last_iter) state_q <= ST_IDLE;
      end
    end
  end

  assign done = done_q;
endmodule

// File: rtl/xbar_match_chk.sv
module xbar_match_chk #(
  parameter int N = 16,
  parameter int MAX_ITER = 4,
  localparam int LW = $clog2(N),
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [N-1:0]    match_vld,
  input logic [N*LW-1:0] match_out,
  input logic [N*N-1:0]  req_q,
  input logic [N-1:0]    out_m,
  input logic [IW-1:0]   iter_q
);
  // R2
  pair_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match_vld) == $countones(out_m));

  for (genvar i = 0; i < N; i++) begin : g_pair
    // R2
    pair_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_vld[i] |-> req_q[i*N + int'(match_out[i*LW +: LW])]);
    // R2
    idle_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !match_vld[i] |-> (match_out[i*LW +: LW] == '0));
  end

  // R6
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(iter_q) < MAX_ITER));

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(match_vld) && $stable(match_out)));
endmodule

bind rr_xbar_matcher xbar_match_chk #(.N(N), .MAX_ITER(MAX_ITER)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .match_vld(match_vld), .match_out(match_out), .req_q(req_q),
  .out_m(out_m), .iter_q(iter_q)
);

// File: tb/rr_xbar_matcher_test.sv
module rr_xbar_matcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int IT = 3;
  localparam int LW = $clog2(NP);

  typedef struct {
    logic [NP-1:0]    vld;
    logic [NP*LW-1:0] outv;
    logic [NP*NP-1:0] mat;
    int               done_cyc;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NP*NP-1:0] req_mat = '0;
  logic done;
  logic [NP-1:0] match_vld;
  logic [NP*LW-1:0] match_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit fin = 1'b0;
  bit have_last = 1'b0;
  exp_t last_exp;
  exp_t q[$];
  int rp[NP];
  int gp[NP];
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  rr_xbar_matcher #(.N(NP), .MAX_ITER(IT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mat(req_mat),
    .done(done), .match_vld(match_vld), .match_out(match_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  function automatic logic [63:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr;
  endfunction

  // independent model: returns rounds run and fills expectation
  task automatic model(input logic [NP*NP-1:0] m, output exp_t e, output int k);
    bit im[NP];
    bit om[NP];
    int rq[NP];
    int gi[NP];
    int got;
    bit stop;
    e.vld = '0; e.outv = '0; e.mat = m;
    for (int i = 0; i < NP; i++) begin im[i] = 0; om[i] = 0; end
    k = 0; stop = 0;
    for (int it = 0; it < IT; it++) begin
      if (!stop) begin
        for (int i = 0; i < NP; i++) begin
          rq[i] = -1;
          if (!im[i])
            for (int s = NP - 1; s >= 0; s--)
              if (m[i*NP + (rp[i]+s)%NP] && !om[(rp[i]+s)%NP]) rq[i] = (rp[i]+s)%NP;
        end
        for (int o = 0; o < NP; o++) begin
          gi[o] = -1;
          if (!om[o])
            for (int s = NP - 1; s >= 0; s--)
              if (rq[(gp[o]+s)%NP] == o) gi[o] = (gp[o]+s)%NP;
        end
        k++; got = 0;
        for (int o = 0; o < NP; o++)
          if (gi[o] >= 0) begin
            got++;
            im[gi[o]] = 1; om[o] = 1;
            e.vld[gi[o]] = 1'b1;
            e.outv[gi[o]*LW +: LW] = LW'(o);
            if (it == 0) begin
              gp[o] = (gp[o] + 1) % NP;
              rp[gi[o]] = (rp[gi[o]] + 1) % NP;
            end
          end
        if (got == 0) stop = 1;
      end
    end
  endtask

  // driver: predicts, pushes, then stimulates
  task automatic run_op(input logic [NP*NP-1:0] m, input bit extra, input string tag);
    exp_t e;
    int k;
    @(negedge clk);
    if (have_last) begin
      // R7 results held since done, strobe gone
      check(match_vld == last_exp.vld && match_out == last_exp.outv && !done,
            {"R7 hold ", last_exp.tag}, {match_vld, match_out, 7'd0, done},
            {last_exp.vld, last_exp.outv, 8'd0});
    end
    model(m, e, k);
    e.done_cyc = cyc + 1 + k;
    e.tag = tag;
    q.push_back(e);
    start = 1'b1; req_mat = m;
    @(negedge clk);
    start = 1'b0;
    if (extra && k >= 2) begin
      // R9 start during busy rounds with a different matrix
      start = 1'b1; req_mat = ~m;
    end
    @(negedge clk);
    start = 1'b0; req_mat = '0;
    while (cyc <= e.done_cyc) @(negedge clk);
    last_exp = e; have_last = 1'b1;
  endtask

  // monitor: pops and compares on each done
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R6 done without a pending slot", 1, 0);
      end else begin
        exp_t e;
        bit one2one;
        bit r8ok;
        e = q.pop_front();
        check(cyc == e.done_cyc, {"R6 latency ", e.tag}, cyc, e.done_cyc);
        check(match_vld == e.vld && match_out == e.outv, {"R3/R4/R5 match ", e.tag},
              {match_vld, match_out}, {e.vld, e.outv});
        one2one = 1'b1;
        for (int a = 0; a < NP; a++) begin
          if (match_vld[a] && !e.mat[a*NP + int'(match_out[a*LW +: LW])]) one2one = 1'b0;
          if (!match_vld[a] && match_out[a*LW +: LW] != '0) one2one = 1'b0;
          for (int b = a + 1; b < NP; b++)
            if (match_vld[a] && match_vld[b] && match_out[a*LW +: LW] == match_out[b*LW +: LW])
              one2one = 1'b0;
        end
        check(one2one, {"R2 one-to-one ", e.tag}, {match_vld, match_out}, {e.vld, e.outv});
        r8ok = 1'b1;
        for (int a = 0; a < NP; a++)
          if (e.mat[a*NP +: NP] == '0 && match_vld[a]) r8ok = 1'b0;
        check(r8ok, {"R8 empty rows unmatched ", e.tag}, match_vld, e.vld);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NP*NP-1:0] m;
    for (int i = 0; i < NP; i++) begin rp[i] = 0; gp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!done && match_vld == '0 && match_out == '0, "R1 reset outputs", {done, match_vld}, 0);
    // R1 pointers at zero are shown by the first full-matrix slot
    run_op({NP*NP{1'b1}}, 1'b0, "R1 full matrix from reset");
    run_op('0, 1'b0, "R8 empty matrix");
    for (int r = 0; r < 4; r++) run_op({NP*NP{1'b1}}, 1'b0, "R5 full matrix desync");
    m = '0;
    for (int i = 0; i < NP; i++) m[i*NP + i] = 1'b1;
    run_op(m, 1'b1, "R3 identity");
    m = '0;
    for (int i = 0; i < NP; i++) m[i*NP + 3] = 1'b1;
    for (int r = 0; r < 3; r++) run_op(m, 1'b0, "R4 single column rotation");
    m = '0;
    for (int i = 0; i < NP; i++) m[i*NP + (NP-1-i)] = 1'b1;
    run_op(m, 1'b1, "R3 anti-diagonal");
    for (int r = 0; r < 30; r++) begin
      m = rnd();
      if (r % 3 == 1) m = m & rnd();
      if (r % 4 == 2) m[2*NP +: NP] = '0;
      run_op(m, r[0], r[0] ? "R9 random with busy start" : "R8 random");
    end
    run_op('0, 1'b0, "R7 final empty");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R6 every slot reported done", q.size(), 0);
    check(match_vld == '0 && !done, "R7 final hold", {done, match_vld}, 0);
    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule